// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Tracker

This block keeps the one reservation that a processor's L1 data cache may hold for an atomic load-reserve / store-conditional pair. A load-reserve records the block address and asks for an address-only bus tenure that announces the reservation. A load-reserve that missed asks for a read-atomic tenure instead. Snooped bus traffic from other masters is compared against the reserved block. Writes, read-with-intent-to-modify and kills to that block drop the reservation. A flush only invalidates the local copy, and the reservation survives it.

A store-conditional succeeds when the reservation is still held at its decision point. On an exclusive or modified line that point is the cycle it is accepted. On a shared line the block first queues a kill tenure, which may target an address other than the reserved one, and decides when that kill is granted. A kill that is granted after the reservation was lost still completes on the bus. The store-conditional then fails and the line is not marked modified. When a flush lands between a load-reserve hit and its announcement, the announcement still goes out, and the load-reserve is then retried as a read-atomic tenure. The cache and the bus arbiter are seen only through request, grant and retry wires.

Top module: `lrsc_reservation_tracker`

## Requirements
- R1: An accepted load-reserve raises `rsv_valid` and `abus_req` in the next cycle, with `abus_addr` equal to the load-reserve address. `abus_tt` is 5'b00001 (reservation announce) on a hit and 5'b11010 (read-atomic) on a miss.
- R2: A bus request keeps its `abus_tt` and `abus_addr` and stays raised until a cycle with `abus_gnt`=1 and `abus_artry`=0. It is low in the cycle after that grant. A grant with `abus_artry`=1 changes nothing.
- R3: While the reservation announce is pending, a snoop with op 0 (write), 1 (read-with-intent-to-modify) or 3 (kill) to the reserved address withdraws the request and clears `rsv_valid` in the next cycle. Snoops to other addresses leave both unchanged.
- R4: A snooped flush (op 2) to the reserved address leaves `rsv_valid` high. If it arrives before the announce is granted, the announce still completes. In the cycle after that grant, `lr_retry` pulses and a read-atomic request to the reserved address is raised.
- R5: A store-conditional with the reservation held and line state 2'b10 (exclusive) or 2'b11 (modified) gives, in the next cycle, `sc_done`=1, `sc_ok`=1 and `ln_mark_mod`=1 with `ln_addr` equal to its address.
- R6: A store-conditional with the reservation held and line state 2'b01 (shared) raises a kill request (`abus_tt`=5'b01100) to its own address, whether or not that address matches the reserved one. `sc_done` is given in the cycle after the kill grant. If the reservation is still held at the grant, it completes with `sc_ok`=1 and `ln_mark_mod`=1.
- R7: If the reservation is lost while a kill is queued, the kill request stays raised and completes. The store-conditional then ends with `sc_done`=1, `sc_ok`=0 and `ln_mark_mod`=0.
- R8: A store-conditional with no reservation, or with line state 2'b00 (invalid), fails in the next cycle with no bus request and no modified mark.
- R9: `rsv_valid` is low in every cycle in which `sc_done` is high.
- R10: After reset, `rsv_valid`, `abus_req`, `sc_done`, `ln_mark_mod` and `lr_retry` are low and `lr_ready` is high.
- R11: `lr_ready` is low while any bus tenure is pending, and a store-conditional is accepted only when `sc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_valid | input | 1 | Load-reserve request |
| lr_hit | input | 1 | Load-reserve hit in the L1 data cache |
| lr_addr | input | AW | Load-reserve block address |
| lr_ready | output | 1 | Load-reserve can be accepted |
| lr_retry | output | 1 | Pulse: load-reserve re-run as a read-atomic tenure |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | AW | Store-conditional block address |
| sc_line_st | input | 2 | Line state at the store-conditional address (I=00, S=01, E=10, M=11) |
| sc_ready | output | 1 | Store-conditional can be accepted |
| sc_done | output | 1 | Pulse: store-conditional resolved |
| sc_ok | output | 1 | Store-conditional succeeded (valid with sc_done) |
| ln_mark_mod | output | 1 | Pulse: mark the line at ln_addr modified |
| ln_addr | output | AW | Line to mark modified |
| snp_valid | input | 1 | Snooped bus operation present |
| snp_op | input | 2 | Snoop kind: 0 write, 1 read-with-intent-to-modify, 2 flush, 3 kill |
| snp_addr | input | AW | Snooped block address |
| abus_req | output | 1 | Address bus request |
| abus_tt | output | 5 | Transfer type of the pending tenure |
| abus_addr | output | AW | Address of the pending tenure |
| abus_gnt | input | 1 | Address bus grant |
| abus_artry | input | 1 | Retry response in the grant cycle |
| rsv_valid | output | 1 | Reservation currently held |

## Verification
Every result is registered, so each one is due one clock edge after the stimulus that causes it. A load-reserve or store-conditional shows its request or its verdict one edge after acceptance. A snoop changes `rsv_valid` one edge after it is seen. A grant ends a request, and starts a follow-on retry request or a store-conditional verdict, on the edge that takes it. The bench drives on falling edges and samples on the following falling edge, which is exactly one rising edge later. It grants pending tenures one cycle at a time, so every check falls on the cycle its result is due.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RSET = 2'd1,
        ST_RDAT = 2'd2,
        ST_KILL = 2'd3
    } trk_st_e;

    localparam int TTW = 5;
    localparam logic [TTW-1:0] TT_RSV_SET = 5'b00001;
    localparam logic [TTW-1:0] TT_KILL    = 5'b01100;
    localparam logic [TTW-1:0] TT_RD_ATOM = 5'b11010;

    localparam logic [1:0] SNP_WR    = 2'd0;
    localparam logic [1:0] SNP_RWITM = 2'd1;
    localparam logic [1:0] SNP_FLUSH = 2'd2;
    localparam logic [1:0] SNP_KILL  = 2'd3;

    localparam logic [1:0] LN_I = 2'b00;
    localparam logic [1:0] LN_S = 2'b01;
    localparam logic [1:0] LN_E = 2'b10;
    localparam logic [1:0] LN_M = 2'b11;

endpackage

// File: rtl/lrsc_snoop_filter.sv
module lrsc_snoop_filter
    import lrsc_pkg::*;
#(
    parameter int AW = 26
) (
    input  logic          snp_valid,
    input  logic [1:0]    snp_op,
    input  logic [AW-1:0] snp_addr,
    input  logic          rsv_held,
    input  logic [AW-1:0] rsv_addr,
    output logic          hit_cancel,
    output logic          hit_flush
);
    logic on_block;

    always_comb begin
        on_block   = snp_valid && rsv_held && (snp_addr == rsv_addr);
        hit_flush  = on_block && (snp_op == SNP_FLUSH);
        hit_cancel = on_block && (snp_op != SNP_FLUSH);
    end

endmodule

// File: rtl/lrsc_bus_slot.sv
module lrsc_bus_slot
    import lrsc_pkg::*;
#(
    parameter int AW = 26
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [TTW-1:0] load_tt,
    input  logic [AW-1:0]  load_addr,
    input  logic           abort,
    input  logic           gnt,
    input  logic           artry,
    output logic           req,
    output logic [TTW-1:0] tt,
    output logic [AW-1:0]  addr,
    output logic           done
);
    typedef struct packed {
        logic           req;
        logic [TTW-1:0] tt;
        logic [AW-1:0]  addr;
    } slot_s;

    slot_s slot_d, slot_q;

    always_comb begin
        done   = slot_q.req && gnt && !artry;
        slot_d = slot_q;
        if (load) begin
            slot_d.req  = 1'b1;
            slot_d.tt   = load_tt;
            slot_d.addr = load_addr;
        end else if (abort || done) begin
            slot_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign req  = slot_q.req;
    assign tt   = slot_q.tt;
    assign addr = slot_q.addr;

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !abort && !(gnt && !artry)) |=> (req && $stable(tt) && $stable(addr)));

    assert_req_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && gnt && !artry && !load) |=> !req);

endmodule

// File: rtl/lrsc_reservation_tracker.sv
module lrsc_reservation_tracker
    import lrsc_pkg::*;
#(
    parameter int AW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lr_valid,
    input  logic          lr_hit,
    input  logic [AW-1:0] lr_addr,
    output logic          lr_ready,
    output logic          lr_retry,
    input  logic          sc_valid,
    input  logic [AW-1:0] sc_addr,
    input  logic [1:0]    sc_line_st,
    output logic          sc_ready,
    output logic          sc_done,
    output logic          sc_ok,
    output logic          ln_mark_mod,
    output logic [AW-1:0] ln_addr,
    input  logic          snp_valid,
    input  logic [1:0]    snp_op,
    input  logic [AW-1:0] snp_addr,
    output logic          abus_req,
    output logic [4:0]    abus_tt,
    output logic [AW-1:0] abus_addr,
    input  logic          abus_gnt,
    input  logic          abus_artry,
    output logic          rsv_valid
);
    typedef struct packed {
        trk_st_e       st;
        logic          rsv;
        logic [AW-1:0] rsv_addr;
        logic          lost;
        logic [AW-1:0] sc_addr;
        logic          sc_done;
        logic          sc_ok;
        logic          mark;
        logic [AW-1:0] mark_addr;
        logic          lr_retry;
    } trk_s;

    trk_s trk_d, trk_q;

    logic           cancel, flush_hit, bus_done;
    logic           slot_load, slot_abort;
    logic [TTW-1:0] slot_tt;
    logic [AW-1:0]  slot_addr;
    logic           held_now;

    lrsc_snoop_filter #(.AW(AW)) u_filter (
        .snp_valid  (snp_valid),
        .snp_op     (snp_op),
        .snp_addr   (snp_addr),
        .rsv_held   (trk_q.rsv),
        .rsv_addr   (trk_q.rsv_addr),
        .hit_cancel (cancel),
        .hit_flush  (flush_hit)
    );

    lrsc_bus_slot #(.AW(AW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (slot_load),
        .load_tt   (slot_tt),
        .load_addr (slot_addr),
        .abort     (slot_abort),
        .gnt       (abus_gnt),
        .artry     (abus_artry),
        .req       (abus_req),
        .tt        (abus_tt),
        .addr      (abus_addr),
        .done      (bus_done)
    );

    assign lr_ready = (trk_q.st == ST_IDLE);
    assign sc_ready = (trk_q.st == ST_IDLE) && !lr_valid;

    always_comb begin
        trk_d          = trk_q;
        trk_d.sc_done  = 1'b0;
        trk_d.sc_ok    = 1'b0;
        trk_d.mark     = 1'b0;
        trk_d.lr_retry = 1'b0;
        slot_load      = 1'b0;
        slot_abort     = 1'b0;
        slot_tt        = TT_RSV_SET;
        slot_addr      = '0;
        held_now       = trk_q.rsv && !cancel;

        if (cancel) begin
            trk_d.rsv = 1'b0;
        end

        case (trk_q.st)
            ST_IDLE: begin
                if (lr_valid) begin
                    trk_d.rsv      = 1'b1;
                    trk_d.rsv_addr = lr_addr;
                    trk_d.lost     = 1'b0;
                    slot_load      = 1'b1;
                    slot_addr      = lr_addr;
                    slot_tt        = lr_hit ? TT_RSV_SET : TT_RD_ATOM;
                    trk_d.st       = lr_hit ? ST_RSET : ST_RDAT;
                end else if (sc_valid) begin
                    if (held_now && sc_line_st == LN_S) begin
                        slot_load     = 1'b1;
                        slot_tt       = TT_KILL;
                        slot_addr     = sc_addr;
                        trk_d.sc_addr = sc_addr;
                        trk_d.st      = ST_KILL;
                    end else begin
                        trk_d.sc_done   = 1'b1;
                        trk_d.sc_ok     = held_now && (sc_line_st != LN_I);
                        trk_d.mark      = held_now && (sc_line_st != LN_I);
                        trk_d.mark_addr = sc_addr;
                        trk_d.rsv       = 1'b0;
                    end
                end
            end
            ST_RSET: begin
                if (cancel) begin
                    slot_abort = 1'b1;
                    trk_d.st   = ST_IDLE;
                end else begin
                    if (flush_hit) begin
                        trk_d.lost = 1'b1;
                    end
                    if (bus_done) begin
                        if (trk_q.lost || flush_hit) begin
                            slot_load      = 1'b1;
                            slot_tt        = TT_RD_ATOM;
                            slot_addr      = trk_q.rsv_addr;
                            trk_d.lr_retry = 1'b1;
                            trk_d.lost     = 1'b0;
                            trk_d.st       = ST_RDAT;
                        end else begin
                            trk_d.st = ST_IDLE;
                        end
                    end
                end
            end
            ST_RDAT: begin
                if (bus_done) begin
                    trk_d.st = ST_IDLE;
                end
            end
            ST_KILL: begin
                if (bus_done) begin
                    trk_d.sc_done   = 1'b1;
                    trk_d.sc_ok     = held_now;
                    trk_d.mark      = held_now;
                    trk_d.mark_addr = trk_q.sc_addr;
                    trk_d.rsv       = 1'b0;
                    trk_d.st        = ST_IDLE;
                end
            end
            default: trk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign rsv_valid   = trk_q.rsv;
    assign sc_done     = trk_q.sc_done;
    assign sc_ok       = trk_q.sc_ok;
    assign ln_mark_mod = trk_q.mark;
    assign ln_addr     = trk_q.mark_addr;
    assign lr_retry    = trk_q.lr_retry;

    assert_lr_hit_announce_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_valid && lr_ready && lr_hit) |=> (rsv_valid && abus_req && abus_tt == TT_RSV_SET));

    assert_lr_miss_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_valid && lr_ready && !lr_hit) |=> (rsv_valid && abus_req && abus_tt == TT_RD_ATOM));

    assert_announce_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == ST_RSET && cancel) |=> (!abus_req && !rsv_valid));

    assert_flush_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_hit && !sc_valid && trk_q.st != ST_KILL) |=> rsv_valid);

    assert_mark_only_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ln_mark_mod |-> (sc_done && sc_ok));

    assert_kill_survives_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.st == ST_KILL && abus_req && !bus_done) |=> abus_req);

    assert_fail_no_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && !sc_ok) |-> !ln_mark_mod);

    assert_sc_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |-> !rsv_valid);

    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abus_req |-> !lr_ready);

endmodule

// File: tb/lrsc_reservation_tracker_bench.sv
`timescale 1ns/1ps
module lrsc_reservation_tracker_bench;
    localparam int AW = 26;
    localparam logic [1:0] OP_WR = 2'd0, OP_RWITM = 2'd1, OP_FLUSH = 2'd2, OP_KILL = 2'd3;
    localparam logic [1:0] L_I = 2'b00, L_S = 2'b01, L_E = 2'b10, L_M = 2'b11;
    localparam logic [4:0] T_RSV = 5'b00001, T_KILL = 5'b01100, T_RDA = 5'b11010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lr_valid = 1'b0, lr_hit = 1'b0;
    logic [AW-1:0] lr_addr = '0;
    logic lr_ready, lr_retry;
    logic sc_valid = 1'b0;
    logic [AW-1:0] sc_addr = '0;
    logic [1:0] sc_line_st = 2'b00;
    logic sc_ready, sc_done, sc_ok, ln_mark_mod;
    logic [AW-1:0] ln_addr;
    logic snp_valid = 1'b0;
    logic [1:0] snp_op = 2'b00;
    logic [AW-1:0] snp_addr = '0;
    logic abus_req;
    logic [4:0] abus_tt;
    logic [AW-1:0] abus_addr;
    logic abus_gnt = 1'b0, abus_artry = 1'b0;
    logic rsv_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lrsc_reservation_tracker #(.AW(AW)) u_lrsc_reservation_tracker (
        .clk(clk), .rst_n(rst_n),
        .lr_valid(lr_valid), .lr_hit(lr_hit), .lr_addr(lr_addr),
        .lr_ready(lr_ready), .lr_retry(lr_retry),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_line_st(sc_line_st),
        .sc_ready(sc_ready), .sc_done(sc_done), .sc_ok(sc_ok),
        .ln_mark_mod(ln_mark_mod), .ln_addr(ln_addr),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .abus_req(abus_req), .abus_tt(abus_tt), .abus_addr(abus_addr),
        .abus_gnt(abus_gnt), .abus_artry(abus_artry),
        .rsv_valid(rsv_valid)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic exp_sc_ok(input logic held, input logic [1:0] st);
        return held && (st != L_I);
    endfunction

    task automatic lr_go(input logic [AW-1:0] a, input logic hit);
        lr_valid = 1'b1; lr_addr = a; lr_hit = hit;
        @(negedge clk);
        lr_valid = 1'b0;
    endtask

    task automatic sc_go(input logic [AW-1:0] a, input logic [1:0] st);
        sc_valid = 1'b1; sc_addr = a; sc_line_st = st;
        @(negedge clk);
        sc_valid = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic grant(input logic rty);
        abus_gnt = 1'b1; abus_artry = rty;
        @(negedge clk);
        abus_gnt = 1'b0; abus_artry = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 4; k++) begin
            if (abus_req) grant(1'b0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] ra, rb;
        logic mrsv;
        logic [AW-1:0] maddr;
        void'($urandom(32'd1291));
        ra = 26'h0123;
        rb = 26'h0456;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 rsv_valid", rsv_valid, 0);
        check("R10 abus_req", abus_req, 0);
        check("R10 sc_done", sc_done, 0);
        check("R10 mark", ln_mark_mod, 0);
        check("R10 lr_retry", lr_retry, 0);
        check("R10 lr_ready", lr_ready, 1);

        // R1 hit -> announce
        lr_go(ra, 1'b1);
        check("R1 rsv_valid", rsv_valid, 1);
        check("R1 req", abus_req, 1);
        check("R1 tt", abus_tt, T_RSV);
        check("R1 addr", abus_addr, ra);
        check("R11 lr_ready busy", lr_ready, 0);
        snoop(OP_WR, rb);
        check("R3 other addr rsv", rsv_valid, 1);
        check("R3 other addr req", abus_req, 1);
        grant(1'b1);
        check("R2 artry keeps req", abus_req, 1);
        check("R2 artry keeps tt", abus_tt, T_RSV);
        grant(1'b0);
        check("R2 req ends", abus_req, 0);
        check("R2 rsv kept", rsv_valid, 1);
        check("R4 no retry", lr_retry, 0);

        // R5 store-conditional on modified line
        sc_go(ra, L_M);
        check("R5 done", sc_done, 1);
        check("R5 ok", sc_ok, 1);
        check("R5 mark", ln_mark_mod, 1);
        check("R5 addr", ln_addr, ra);
        check("R9 rsv cleared", rsv_valid, 0);
        check("R5 no bus", abus_req, 0);
        @(negedge clk);
        check("R5 pulse ends", sc_done, 0);

        // R3 cancel of pending announce
        lr_go(ra, 1'b1);
        snoop(OP_KILL, ra);
        check("R3 cancel rsv", rsv_valid, 0);
        check("R3 cancel req", abus_req, 0);

        // R4 flush before announce grant
        lr_go(ra, 1'b1);
        snoop(OP_FLUSH, ra);
        check("R4 flush keeps rsv", rsv_valid, 1);
        check("R4 flush keeps req", abus_req, 1);
        grant(1'b0);
        check("R4 retry pulse", lr_retry, 1);
        check("R4 read-atomic req", abus_req, 1);
        check("R4 read-atomic tt", abus_tt, T_RDA);
        check("R4 read-atomic addr", abus_addr, ra);
        grant(1'b0);
        check("R4 done req", abus_req, 0);
        check("R4 rsv after", rsv_valid, 1);

        // R6 kill on shared line at a different address
        sc_go(rb, L_S);
        check("R6 kill req", abus_req, 1);
        check("R6 kill tt", abus_tt, T_KILL);
        check("R6 kill addr", abus_addr, rb);
        check("R6 no done yet", sc_done, 0);
        check("R6 rsv held", rsv_valid, 1);
        check("R11 sc_ready busy", sc_ready, 0);
        grant(1'b0);
        check("R6 done", sc_done, 1);
        check("R6 ok", sc_ok, 1);
        check("R6 mark", ln_mark_mod, 1);
        check("R6 mark addr", ln_addr, rb);
        check("R9 rsv cleared kill", rsv_valid, 0);

        // R1 miss, then R7 reservation lost under a queued kill
        lr_go(ra, 1'b0);
        check("R1 miss tt", abus_tt, T_RDA);
        check("R1 miss rsv", rsv_valid, 1);
        grant(1'b0);
        sc_go(ra, L_S);
        snoop(OP_RWITM, ra);
        check("R7 rsv lost", rsv_valid, 0);
        check("R7 kill stays", abus_req, 1);
        grant(1'b0);
        check("R7 done", sc_done, 1);
        check("R7 fail", sc_ok, 0);
        check("R7 no mark", ln_mark_mod, 0);

        // R8 no reservation / invalid line
        sc_go(ra, L_M);
        check("R8 done", sc_done, 1);
        check("R8 fail", sc_ok, 0);
        check("R8 no mark", ln_mark_mod, 0);
        check("R8 no bus", abus_req, 0);
        lr_go(ra, 1'b1);
        drain();
        sc_go(ra, L_I);
        check("R8 invalid fail", sc_ok, 0);
        check("R8 invalid done", sc_done, 1);

        // R4 flush while idle keeps the reservation
        lr_go(rb, 1'b1);
        drain();
        snoop(OP_FLUSH, rb);
        check("R4 idle flush", rsv_valid, 1);
        sc_go(rb, L_E);
        check("R5 exclusive ok", sc_ok, 1);

        // random phase against a bench model
        mrsv = 1'b0;
        maddr = '0;
        for (int it = 0; it < 400; it++) begin
            int kind;
            logic [AW-1:0] a;
            kind = $urandom_range(0, 2);
            a = AW'($urandom_range(0, 3));
            if (kind == 0) begin
                lr_go(a, 1'($urandom_range(0, 1)));
                drain();
                mrsv = 1'b1;
                maddr = a;
                check("R1 random rsv", rsv_valid, mrsv);
            end else if (kind == 1) begin
                logic [1:0] st;
                st = 2'($urandom_range(0, 3));
                sc_go(a, st);
                if (!sc_done) grant(1'b0);
                check("R6 random done", sc_done, 1);
                check("R5 random ok", sc_ok, exp_sc_ok(mrsv, st));
                check("R8 random mark", ln_mark_mod, exp_sc_ok(mrsv, st));
                mrsv = 1'b0;
                check("R9 random rsv", rsv_valid, mrsv);
            end else begin
                logic [1:0] op;
                op = 2'($urandom_range(0, 3));
                snoop(op, a);
                if (mrsv && a == maddr && op != OP_FLUSH) mrsv = 1'b0;
                check("R3 random snoop", rsv_valid, mrsv);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule